// File: doc/BRIEF.md
# Otsu Threshold Binarization Engine

This block turns a grayscale image into a black-and-white one. It picks the threshold itself, using the between-class-variance criterion. Pixels arrive as a stream of 8-bit values and the image is streamed into the block twice.

On the first pass the engine builds a 256-bin intensity histogram. It then steps through every candidate threshold, one per clock. At each step it updates the running class-0 pixel count and intensity sum, and it scores the two-class split with integer cross-multiplication, so no divider is needed. Two best-so-far trackers are kept:
- one replaces its entry only on a strictly larger score;
- one replaces its entry on a larger or equal score.

The chosen threshold is the floor of the mean of their two levels, which puts the result in the middle of a flat plateau. On the second pass each accepted pixel yields one output bit.

Software drives the engine through a small Wishbone-style slave. It writes the pixel count of the frame, starts the run, polls for completion and reads back the threshold.

Top module: `otsu_binarizer`

## Requirements
- R1: After reset, the status register reads 0 (not busy, not done), the threshold register reads 0, the frame length register reads 0, and `binValid` is low.
- R2: The register word addresses are as follows. Address 0 is control/status: a write with bit 0 set starts a frame, and a read returns busy in bit 0 and done in bit 1. Address 1 is the frame pixel count (read/write). Address 2 returns the threshold in bits 7:0. Each request is answered with a one-cycle `wbAck` on the clock after it is presented.
- R3: The histogram counts exactly the frame-length number of pixels presented with `pixValid` during the accumulate phase. The accumulate phase begins 256 cycles after the start write. Pixels presented while idle, while clearing or while sweeping are ignored and produce no output.
- R4: The threshold t is the level that maximises (S·w0 − m0·N)² / (w0·(N − w0)), where w0 is the number of pixels with value ≤ t, m0 is their intensity sum, N is the pixel count and S is the total intensity sum. Levels where w0 = 0 or w0 = N are skipped.
- R5: On a plateau of equal maximal scores, the threshold is floor((first maximising level + last maximising level) / 2). For example, an image split evenly between levels 50 and 200 gives 124.
- R6: If no level qualifies (all pixels share one value, or N = 0), the threshold is 0.
- R7: Done is cleared by a start and set once the sweep has finished, before the binarize pass. After the binarize pass has ended, done remains set while busy is low.
- R8: In the binarize pass, each accepted pixel yields `binValid` high on the following cycle, with `binBit` = 1 exactly when the pixel is greater than the threshold. After frame-length outputs the engine returns to idle.
- R9: A start write while busy is ignored, and so is a frame-length write while busy. The running frame continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wbCyc | input | 1 | Bus cycle valid |
| wbStb | input | 1 | Bus strobe |
| wbWe | input | 1 | Write enable |
| wbAdr | input | 2 | Register word address |
| wbDatI | input | 32 | Write data |
| wbDatO | output | 32 | Read data |
| wbAck | output | 1 | Transfer acknowledge |
| pixValid | input | 1 | Pixel present on pixData |
| pixData | input | 8 | Grayscale pixel |
| binValid | output | 1 | Binary output bit valid |
| binBit | output | 1 | Binary pixel (1 = above threshold) |

## Verification
A corrupted histogram bin or running sum changes the sweep score. It appears as a wrong threshold when the threshold register is read, at the latest 258 cycles after the last pixel of the first pass. A control counter that is off by one shows up as a missing or extra `binValid` pulse at the end of the second pass, or as done never being set. A tracker that uses the wrong comparison only shows on plateau images, so the even two-level image pins the strict and the inclusive tie rule to the exact value 124. A threshold that is right but applied wrongly shows up on the first binary bit that differs from pixel > threshold.

// File: rtl/otsu_pkg.sv
package otsu_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CLEAR,
    PH_ACCUM,
    PH_SWEEP,
    PH_FINAL,
    PH_BIN
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearBin;
    logic accumEn;
    logic sweepStep;
    logic finalize;
    logic binEn;
  } strobe_t;

  localparam logic [1:0] ADR_CTRL  = 2'd0;
  localparam logic [1:0] ADR_FRAME = 2'd1;
  localparam logic [1:0] ADR_THR   = 2'd2;

endpackage

// File: rtl/otsu_regs.sv
module otsu_regs
  import otsu_pkg::*;
#(
  parameter int CW    = 13,
  parameter int PIX_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic [1:0]        wbAdr,
  input  logic [31:0]       wbDatI,
  output logic [31:0]       wbDatO,
  output logic              wbAck,
  input  logic              busy,
  input  logic              done,
  input  logic [PIX_W-1:0]  thr,
  output logic [CW-1:0]     frameLen,
  output logic              startPulse
);

  logic req;
  logic unusedDat;

  assign req        = wbCyc & wbStb & ~wbAck;
  assign startPulse = req & wbWe & (wbAdr == ADR_CTRL) & wbDatI[0];
  assign unusedDat  = ^wbDatI[31:CW];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbAck    <= 1'b0;
      wbDatO   <= '0;
      frameLen <= '0;
    end else begin
      wbAck <= req;
      if (req && wbWe && wbAdr == ADR_FRAME && !busy)
        frameLen <= wbDatI[CW-1:0];
      if (req && !wbWe) begin
        case (wbAdr)
          ADR_CTRL:  wbDatO <= {30'd0, done, busy};
          ADR_FRAME: wbDatO <= 32'(frameLen);
          ADR_THR:   wbDatO <= 32'(thr);
          default:   wbDatO <= '0;
        endcase
      end
    end
  end

  // R2
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbAck |=> !wbAck);

endmodule

// File: rtl/otsu_ctrl.sv
module otsu_ctrl
  import otsu_pkg::*;
#(
  parameter int CW    = 13,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [CW-1:0]    frameLen,
  input  logic             pixValid,
  output strobe_t          st,
  output logic [PIX_W-1:0] idx,
  output logic             busy,
  output logic             done
);

  localparam logic [PIX_W-1:0] LAST_IDX = '1;

  phase_t          state;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   frameLat;
  logic            room;

  assign room = (cnt != frameLat);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= PH_IDLE;
      cnt      <= '0;
      frameLat <= '0;
      idx      <= '0;
      done     <= 1'b0;
    end else begin
      case (state)
        PH_IDLE: begin
          if (startPulse) begin
            state    <= PH_CLEAR;
            idx      <= '0;
            done     <= 1'b0;
            frameLat <= frameLen;
          end
        end
        PH_CLEAR: begin
          idx <= idx + PIX_W'(1);
          if (idx == LAST_IDX) begin
            state <= PH_ACCUM;
            cnt   <= '0;
          end
        end
        PH_ACCUM: begin
          if (!room) begin
            state <= PH_SWEEP;
            idx   <= '0;
          end else if (pixValid) begin
            cnt <= cnt + CW'(1);
          end
        end
        PH_SWEEP: begin
          idx <= idx + PIX_W'(1);
          if (idx == LAST_IDX) state <= PH_FINAL;
        end
        PH_FINAL: begin
          state <= PH_BIN;
          done  <= 1'b1;
          cnt   <= '0;
        end
        PH_BIN: begin
          if (!room) state <= PH_IDLE;
          else if (pixValid) cnt <= cnt + CW'(1);
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    st           = '0;
    st.clearBin  = (state == PH_CLEAR);
    st.accumEn   = (state == PH_ACCUM) && pixValid && room;
    st.sweepStep = (state == PH_SWEEP);
    st.finalize  = (state == PH_FINAL);
    st.binEn     = (state == PH_BIN) && pixValid && room;
  end

  assign busy = (state != PH_IDLE);

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != PH_IDLE && state != PH_CLEAR) |=> (state != PH_CLEAR));

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_ACCUM || state == PH_BIN) |-> (cnt <= frameLat));

  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (state == PH_BIN));

endmodule

// File: rtl/otsu_max_track.sv
module otsu_max_track #(
  parameter int NW        = 72,
  parameter int DENW      = 26,
  parameter int PIX_W     = 8,
  parameter bit INCLUSIVE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             cand,
  input  logic [NW-1:0]    candNum,
  input  logic [DENW-1:0]  candDen,
  input  logic [PIX_W-1:0] candThr,
  output logic             have,
  output logic [PIX_W-1:0] bestThr
);

  localparam int PW = NW + DENW;

  logic [NW-1:0]   bestNum;
  logic [DENW-1:0] bestDen;
  logic [PW-1:0]   lhs, rhs;
  logic            beats;

  // score comparison without division
  assign lhs = PW'(candNum) * PW'(bestDen);
  assign rhs = PW'(bestNum) * PW'(candDen);

  generate
    if (INCLUSIVE) begin : g_ge
      assign beats = (lhs >= rhs);
    end else begin : g_gt
      assign beats = (lhs > rhs);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      have    <= 1'b0;
      bestNum <= '0;
      bestDen <= '0;
      bestThr <= '0;
    end else if (cand && (!have || beats)) begin
      have    <= 1'b1;
      bestNum <= candNum;
      bestDen <= candDen;
      bestThr <= candThr;
    end
  end

endmodule

// File: rtl/otsu_datapath.sv
module otsu_datapath
  import otsu_pkg::*;
#(
  parameter int CW    = 13,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [PIX_W-1:0] idx,
  input  logic [PIX_W-1:0] pixData,
  output logic [PIX_W-1:0] thr,
  output logic             binValid,
  output logic             binBit
);

  localparam int BINS = 1 << PIX_W;
  localparam int SW   = CW + PIX_W;
  localparam int PW   = CW + SW;
  localparam int NW   = 2 * PW;
  localparam int DENW = 2 * CW;

  logic [CW-1:0] hist [BINS];
  logic [CW-1:0] totCnt, w0, w0n, hSel;
  logic [SW-1:0] totSum, m0, m0n;
  logic [PW-1:0] pa, pb, ad;
  logic [NW-1:0] candNum;
  logic [DENW-1:0] candDen;
  logic          candOk;
  logic [1:0]    haveArr;
  logic [PIX_W-1:0] thrArr [2];
  logic [PIX_W:0]   thrSum;

  // histogram memory
  always_ff @(posedge clk) begin
    if (st.clearBin) hist[idx] <= '0;
    else if (st.accumEn) hist[pixData] <= hist[pixData] + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.clearBin) begin
      totCnt <= '0;
      totSum <= '0;
      w0     <= '0;
      m0     <= '0;
    end else begin
      if (st.accumEn) begin
        totCnt <= totCnt + CW'(1);
        totSum <= totSum + SW'(pixData);
      end
      if (st.sweepStep) begin
        w0 <= w0n;
        m0 <= m0n;
      end
    end
  end

  // candidate score at level idx
  always_comb begin
    hSel    = hist[idx];
    w0n     = w0 + hSel;
    m0n     = m0 + SW'(hSel) * SW'(idx);
    candOk  = st.sweepStep && (w0n != '0) && (w0n != totCnt);
    pa      = PW'(totSum) * PW'(w0n);
    pb      = PW'(m0n) * PW'(totCnt);
    ad      = (pa >= pb) ? (pa - pb) : (pb - pa);
    candNum = NW'(ad) * NW'(ad);
    candDen = DENW'(w0n) * DENW'(totCnt - w0n);
  end

  generate
    for (genvar g = 0; g < 2; g++) begin : g_trk
      otsu_max_track #(
        .NW(NW), .DENW(DENW), .PIX_W(PIX_W), .INCLUSIVE(g[0])
      ) u_trk (
        .clk(clk), .rstN(rstN), .clr(st.clearBin), .cand(candOk),
        .candNum(candNum), .candDen(candDen), .candThr(idx),
        .have(haveArr[g]), .bestThr(thrArr[g])
      );
    end
  endgenerate

  assign thrSum = {1'b0, thrArr[0]} + {1'b0, thrArr[1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thr      <= '0;
      binValid <= 1'b0;
      binBit   <= 1'b0;
    end else begin
      if (st.finalize) thr <= haveArr[0] ? thrSum[PIX_W:1] : '0;
      binValid <= st.binEn;
      binBit   <= st.binEn && (pixData > thr);
    end
  end

  // R5
  plateau_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (haveArr[0] && haveArr[1]) |-> (thrArr[0] <= thrArr[1]));

  // R4
  tracker_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    haveArr[0] == haveArr[1]);

  // R3
  sum_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.sweepStep |-> (w0n <= totCnt));

endmodule

// File: rtl/otsu_binarizer.sv
module otsu_binarizer
  import otsu_pkg::*;
#(
  parameter int MAX_PIXELS = 4096,
  parameter int PIX_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wbCyc,
  input  logic             wbStb,
  input  logic             wbWe,
  input  logic [1:0]       wbAdr,
  input  logic [31:0]      wbDatI,
  output logic [31:0]      wbDatO,
  output logic             wbAck,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixData,
  output logic             binValid,
  output logic             binBit
);

  localparam int CW = $clog2(MAX_PIXELS + 1);

  strobe_t          st;
  logic [PIX_W-1:0] idx;
  logic [PIX_W-1:0] thr;
  logic [CW-1:0]    frameLen;
  logic             startPulse, busy, done;

  otsu_regs #(.CW(CW), .PIX_W(PIX_W)) u_regs (
    .clk(clk), .rstN(rstN), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbDatI(wbDatI), .wbDatO(wbDatO), .wbAck(wbAck),
    .busy(busy), .done(done), .thr(thr), .frameLen(frameLen),
    .startPulse(startPulse)
  );

  otsu_ctrl #(.CW(CW), .PIX_W(PIX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .frameLen(frameLen),
    .pixValid(pixValid), .st(st), .idx(idx), .busy(busy), .done(done)
  );

  otsu_datapath #(.CW(CW), .PIX_W(PIX_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .idx(idx), .pixData(pixData),
    .thr(thr), .binValid(binValid), .binBit(binBit)
  );

endmodule

// File: tb/otsu_binarizer_tb.sv
`timescale 1ns/1ps
module otsu_binarizer_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wbCyc = 0, wbStb = 0, wbWe = 0;
  logic [1:0] wbAdr = '0;
  logic [31:0] wbDatI = '0;
  logic [31:0] wbDatO;
  logic wbAck;
  logic pixValid = 0;
  logic [7:0] pixData = '0;
  logic binValid, binBit;

  always #2.5 clk = ~clk;

  otsu_binarizer u_dut (
    .clk(clk), .rstN(rstN), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbDatI(wbDatI), .wbDatO(wbDatO), .wbAck(wbAck),
    .pixValid(pixValid), .pixData(pixData), .binValid(binValid), .binBit(binBit)
  );

  int errs = 0, checks = 0;
  int pixBuf [512];
  int nPix = 0;
  int outBits [512];
  int outCnt = 0;

  always @(negedge clk) begin
    if (binValid) begin
      if (outCnt < 512) outBits[outCnt] = int'(binBit);
      outCnt++;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wbWrite(input logic [1:0] a, input logic [31:0] d);
    wbCyc = 1; wbStb = 1; wbWe = 1; wbAdr = a; wbDatI = d;
    do @(negedge clk); while (!wbAck);
    wbCyc = 0; wbStb = 0; wbWe = 0;
    @(negedge clk);
  endtask

  task automatic wbRead(input logic [1:0] a, output logic [31:0] d);
    wbCyc = 1; wbStb = 1; wbWe = 0; wbAdr = a;
    do @(negedge clk); while (!wbAck);
    d = wbDatO;
    wbCyc = 0; wbStb = 0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendPixels(input int first, input int count);
    for (int i = first; i < first + count; i++) begin
      pixValid = 1; pixData = 8'(pixBuf[i]);
      @(negedge clk);
    end
    pixValid = 0;
  endtask

  task automatic sendJunk(input int count, input int v);
    for (int i = 0; i < count; i++) begin
      pixValid = 1; pixData = 8'(v);
      @(negedge clk);
    end
    pixValid = 0;
  endtask

  task automatic waitDone(input string req);
    logic [31:0] s;
    int tries = 0;
    s = 0;
    while (!s[1] && tries < 400) begin
      wbRead(2'd0, s);
      tries++;
    end
    check(req, s[1], 1);
  endtask

  // independent threshold model built from the requirement text
  function automatic int modelThr();
    longint h [256];
    longint tot, sm, w, m;
    logic [191:0] a, b, ad, num, den, nG, dG, nE, dE;
    int tG, tE;
    bit have;
    for (int t = 0; t < 256; t++) h[t] = 0;
    tot = 0; sm = 0;
    for (int i = 0; i < nPix; i++) begin
      h[pixBuf[i]]++; tot++; sm += pixBuf[i];
    end
    w = 0; m = 0; have = 0; tG = 0; tE = 0;
    nG = 0; dG = 0; nE = 0; dE = 0;
    for (int t = 0; t < 256; t++) begin
      w += h[t]; m += t * h[t];
      if (w == 0 || w == tot) continue;
      a = 192'(sm) * 192'(w);
      b = 192'(m) * 192'(tot);
      ad = (a >= b) ? a - b : b - a;
      num = ad * ad;
      den = 192'(w) * 192'(tot - w);
      if (!have || num * dG > nG * den) begin nG = num; dG = den; tG = t; end
      if (!have || num * dE >= nE * den) begin nE = num; dE = den; tE = t; end
      have = 1;
    end
    return have ? (tG + tE) / 2 : 0;
  endfunction

  // full frame: both passes, threshold and bits checked
  task automatic runFrame(input string req, input int expThr, input bit busyStart);
    logic [31:0] d;
    int mThr;
    mThr = modelThr();
    outCnt = 0;
    wbWrite(2'd1, 32'(nPix));
    wbWrite(2'd0, 32'd1);
    wbRead(2'd0, d);
    check({req, " R7 done cleared by start"}, d[1], 0);
    idle(256);
    if (busyStart) begin
      sendPixels(0, nPix / 2);
      wbWrite(2'd0, 32'd1);          // R9 start while busy
      wbWrite(2'd1, 32'd5);          // R9 frame length while busy
      sendPixels(nPix / 2, nPix - nPix / 2);
      wbRead(2'd1, d);
      check("R9 frame length kept", d, nPix);
    end else begin
      sendPixels(0, nPix);
    end
    sendJunk(40, 255);               // R3 ignored during sweep
    waitDone({req, " R7 done"});
    wbRead(2'd2, d);
    check({req, " R4 threshold vs model"}, d, mThr);
    if (expThr >= 0) check({req, " threshold fixed"}, d, expThr);
    check("R3 no output before binarize", outCnt, 0);
    sendPixels(0, nPix);
    idle(4);
    check("R8 output count", outCnt, nPix);
    for (int i = 0; i < nPix; i++)
      check("R8 binary bit", outBits[i], (pixBuf[i] > mThr) ? 1 : 0);
    wbRead(2'd0, d);
    check("R7 done held, not busy", d, 2);
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 binValid low", binValid, 0);
    wbRead(2'd0, d); check("R1 status", d, 0);
    wbRead(2'd2, d); check("R1 threshold", d, 0);
    wbRead(2'd1, d); check("R1 frame length", d, 0);
  endtask

  task automatic testRegs();
    logic [31:0] d;
    int ackCnt;
    wbWrite(2'd1, 32'd37);
    wbRead(2'd1, d); check("R2 frame length readback", d, 37);
    // ack pulse width
    ackCnt = 0;
    wbCyc = 1; wbStb = 1; wbWe = 0; wbAdr = 2'd1;
    @(negedge clk); if (wbAck) ackCnt++;
    wbCyc = 0; wbStb = 0;
    @(negedge clk); if (wbAck) ackCnt++;
    check("R2 single ack", ackCnt, 1);
  endtask

  task automatic testPlateau();
    nPix = 64;
    for (int i = 0; i < 64; i++) pixBuf[i] = (i % 2) ? 200 : 50;
    runFrame("R5 plateau", 124, 0);
  endtask

  task automatic testThreeLevel();
    nPix = 64;
    for (int i = 0; i < 64; i++) pixBuf[i] = (i < 20) ? 10 : (i < 40) ? 100 : 220;
    runFrame("R4 three levels", -1, 0);
  endtask

  task automatic testFlat();
    nPix = 16;
    for (int i = 0; i < 16; i++) pixBuf[i] = 200;
    runFrame("R6 flat image", 0, 0);
  endtask

  task automatic testIdlePixels();
    outCnt = 0;
    sendJunk(20, 255);
    idle(2);
    check("R3 idle pixels produce no output", outCnt, 0);
    nPix = 40;
    for (int i = 0; i < 40; i++) pixBuf[i] = (i * 37 + 11) % 256;
    runFrame("R3 after idle pixels", -1, 0);
  endtask

  task automatic testBusyStart();
    nPix = 32;
    for (int i = 0; i < 32; i++) pixBuf[i] = (i < 12) ? 30 : 180 + i;
    runFrame("R9 start while busy", -1, 1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testRegs();
    testPlateau();
    testThreeLevel();
    testFlat();
    testIdlePixels();
    testBusyStart();
    summary();
    $finish;
  end

endmodule